// File: doc/BRIEF.md
# Transaction Priority and Conflict Arbiter

Each core running hardware transactions carries one of these units. It keeps the priority of the transaction in flight. When the coherence logic flags a conflict with a remote core, the unit compares the local priority with the priority snooped from that core and decides what follows: the remote side is told it lost, the local transaction is asked to abort, or the local transaction is stalled until the winner finishes.

Two priority schemes can be chosen at run time. In the timestamp scheme a counter tracks the largest transaction count seen across the system. The transaction takes that count plus one when it starts, and an older (smaller) count wins. In the work scheme the priority is the number of instructions retired inside the current attempt, and a larger count wins. In both schemes the core number fills the low bits of the priority, so two cores never tie. When the local core made the request and lost, a second run-time choice picks between stalling and aborting. When a remote requester hits a local line and the local transaction loses, the abort is held back until the snoop response shows whether another core has already made the remote side back off.

Top module: `txn_prio_arbiter`

## Requirements
- R1: After reset `abort_o`, `stall_o` and `lose_o` are 0, and `prio_o` equals {count 0, `core_id_i`}. `prio_o` is the count in the high CNT_W bits and the core number in the low ID_W bits.
- R2: A one-cycle `tx_begin_i` raises the system counter by one and fixes the new transaction's timestamp at the raised value. The counter saturates at its all-ones value.
- R3: In the timestamp scheme, a cycle with `snoop_valid_i` whose snooped count is above the system counter loads that count into the counter. A lower snooped count does not change the counter. In the work scheme snooped counts never change the counter. A snoop and a begin in the same cycle give the new transaction the larger of counter and snoop, plus one.
- R4: In the timestamp scheme the local transaction wins a conflict exactly when {local count, local ID} is unsigned-less than {remote count, remote ID}. Equal counts are therefore settled by the lower core number.
- R5: In the work scheme the count clears on `tx_begin_i` and on `tx_abort_i`. It rises by one for each `retire_i` cycle while a transaction is active, saturates at all ones, and ignores `retire_i` when no transaction is active.
- R6: In the work scheme the local transaction wins exactly when its count is larger, or the counts are equal and the local core number is lower.
- R7: When a remote requester (`conf_req_i`=0) beats the local transaction, no abort is raised until `resp_valid_i`. If `resp_other_i` is 0 in that cycle, `abort_o` pulses for one cycle on the next cycle. If it is 1, the decision is dropped.
- R8: When the local core is the requester (`conf_req_i`=1) and loses, the abort policy pulses `abort_o` for one cycle on the next cycle. The stall policy instead raises `stall_o` on the next cycle and holds it until the cycle after `notice_i`.
- R9: Whenever the local transaction wins a conflict, `lose_o` pulses for exactly one cycle, on the cycle after `conflict_i`.
- R10: `cfg_dyn_i` and `cfg_stall_i` are sampled only while no transaction is active. Changes made while a transaction runs do not affect `prio_o` or the chosen rectification.
- R11: `conflict_i` while no transaction is active produces no `lose_o`, `abort_o` or `stall_o`.
- R12: In the timestamp scheme the transaction's count in `prio_o` stays fixed for its whole life, even when a higher snooped count raises the system counter in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_id_i | input | ID_W | Number of this core; low field of the priority |
| cfg_dyn_i | input | 1 | Scheme select: 1 work count, 0 timestamp |
| cfg_stall_i | input | 1 | Requester-loss policy: 1 stall, 0 abort |
| tx_begin_i | input | 1 | Local transaction starts |
| tx_commit_i | input | 1 | Local transaction commits |
| tx_abort_i | input | 1 | Local transaction aborts |
| retire_i | input | 1 | One instruction retired |
| snoop_valid_i | input | 1 | Snooped priority present for counter tracking |
| snoop_prio_i | input | CNT_W+ID_W | Remote priority {count, core number} |
| conflict_i | input | 1 | Conflict with the core whose priority is on snoop_prio_i |
| conf_req_i | input | 1 | 1: local core is the requester; 0: remote requester |
| resp_valid_i | input | 1 | Snoop response for a pending local loss |
| resp_other_i | input | 1 | Remote side was already told to back off by another core |
| notice_i | input | 1 | Winner broadcast its commit or abort |
| prio_o | output | CNT_W+ID_W | Current local priority |
| abort_o | output | 1 | One-cycle request to abort the local transaction |
| stall_o | output | 1 | Local transaction must stall |
| lose_o | output | 1 | One-cycle indication to the remote side that it lost |

## Verification
The bench builds the unit with a 4-bit count and a 2-bit core number. With these sizes every comparison can be swept in both schemes: all local counts, remote counts, local core numbers and remote core numbers, ties included. Saturation of both counters also takes only a few cycles. Directed sequences then cover the pending-abort response, the stall hold and release, counter tracking from snoops, and configuration changes made while a transaction runs.

// File: rtl/txn_prio_pkg.sv
package txn_prio_pkg;
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_WAIT  = 2'd1,
        RS_STALL = 2'd2,
        RS_DOOM  = 2'd3
    } rect_st_e;
endpackage

// File: rtl/txn_prio_track.sv
module txn_prio_track #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dyn_i,
    input  logic             active_i,
    input  logic             tx_begin_i,
    input  logic             tx_abort_i,
    input  logic             retire_i,
    input  logic             snoop_valid_i,
    input  logic [CNT_W-1:0] snoop_cnt_i,
    output logic [CNT_W-1:0] stamp_o,
    output logic [CNT_W-1:0] work_o
);
    localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] glob;
        logic [CNT_W-1:0] stamp;
        logic [CNT_W-1:0] work;
    } trk_t;

    trk_t s_d, s_q;
    logic             raise;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] base_inc;

    always_comb begin
        s_d      = s_q;
        raise    = snoop_valid_i && !dyn_i && (snoop_cnt_i > s_q.glob);
        base     = raise ? snoop_cnt_i : s_q.glob;
        base_inc = (base == CntMax) ? CntMax : base + 1'b1;
        s_d.glob = base;
        if (tx_begin_i) begin
            s_d.glob  = base_inc;
            s_d.stamp = base_inc;
            s_d.work  = '0;
        end else if (tx_abort_i) begin
            s_d.work = '0;
        end else if (retire_i && active_i && (s_q.work != CntMax)) begin
            s_d.work = s_q.work + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign stamp_o = s_q.stamp;
    assign work_o  = s_q.work;
endmodule

// File: rtl/txn_prio_cmp.sv
module txn_prio_cmp #(
    parameter int CNT_W = 16,
    parameter int ID_W  = 3
) (
    input  logic             dyn_i,
    input  logic [CNT_W-1:0] loc_cnt_i,
    input  logic [ID_W-1:0]  loc_id_i,
    input  logic [CNT_W-1:0] rem_cnt_i,
    input  logic [ID_W-1:0]  rem_id_i,
    output logic             local_wins_o
);
    logic id_lower;
    logic cnt_eq;
    logic older;
    logic more_work;

    always_comb begin
        id_lower  = loc_id_i < rem_id_i;
        cnt_eq    = loc_cnt_i == rem_cnt_i;
        older     = (loc_cnt_i < rem_cnt_i) || (cnt_eq && id_lower);
        more_work = (loc_cnt_i > rem_cnt_i) || (cnt_eq && id_lower);
        local_wins_o = dyn_i ? more_work : older;
    end
endmodule

// File: rtl/txn_prio_rectify.sv
module txn_prio_rectify
    import txn_prio_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic stall_pol_i,
    input  logic tx_begin_i,
    input  logic tx_abort_i,
    input  logic tx_commit_i,
    input  logic conflict_i,
    input  logic conf_req_i,
    input  logic local_wins_i,
    input  logic resp_valid_i,
    input  logic resp_other_i,
    input  logic notice_i,
    output logic abort_o,
    output logic stall_o,
    output logic lose_o
);
    typedef struct packed {
        rect_st_e st;
        logic     abort;
        logic     lose;
    } rect_t;

    rect_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.abort = 1'b0;
        r_d.lose  = 1'b0;
        if (tx_begin_i || tx_abort_i || tx_commit_i) begin
            r_d.st = RS_IDLE;
        end else begin
            unique case (r_q.st)
                RS_IDLE: begin
                    if (active_i && conflict_i) begin
                        if (local_wins_i) begin
                            r_d.lose = 1'b1;
                        end else if (!conf_req_i) begin
                            r_d.st = RS_WAIT;
                        end else if (stall_pol_i) begin
                            r_d.st = RS_STALL;
                        end else begin
                            r_d.abort = 1'b1;
                            r_d.st    = RS_DOOM;
                        end
                    end
                end
                RS_STALL: begin
                    if (notice_i) begin
                        r_d.st = RS_IDLE;
                    end else if (conflict_i && !conf_req_i) begin
                        if (local_wins_i) r_d.lose = 1'b1;
                        else              r_d.st   = RS_WAIT;
                    end
                end
                RS_WAIT: begin
                    if (resp_valid_i) begin
                        if (resp_other_i) begin
                            r_d.st = RS_IDLE;
                        end else begin
                            r_d.abort = 1'b1;
                            r_d.st    = RS_DOOM;
                        end
                    end
                end
                default: r_d.st = RS_DOOM;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{st: RS_IDLE, abort: 1'b0, lose: 1'b0};
        else         r_q <= r_d;
    end

    assign abort_o = r_q.abort;
    assign lose_o  = r_q.lose;
    assign stall_o = (r_q.st == RS_STALL);
endmodule

// File: rtl/txn_prio_arbiter.sv
module txn_prio_arbiter #(
    parameter int CNT_W = 16,
    parameter int ID_W  = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [ID_W-1:0]       core_id_i,
    input  logic                  cfg_dyn_i,
    input  logic                  cfg_stall_i,
    input  logic                  tx_begin_i,
    input  logic                  tx_commit_i,
    input  logic                  tx_abort_i,
    input  logic                  retire_i,
    input  logic                  snoop_valid_i,
    input  logic [CNT_W+ID_W-1:0] snoop_prio_i,
    input  logic                  conflict_i,
    input  logic                  conf_req_i,
    input  logic                  resp_valid_i,
    input  logic                  resp_other_i,
    input  logic                  notice_i,
    output logic [CNT_W+ID_W-1:0] prio_o,
    output logic                  abort_o,
    output logic                  stall_o,
    output logic                  lose_o
);
    typedef struct packed {
        logic active;
        logic dyn;
        logic stall_pol;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             active_q;
    logic             dyn_q;
    logic             dyn_eff;
    logic [CNT_W-1:0] stamp;
    logic [CNT_W-1:0] work;
    logic [CNT_W-1:0] loc_cnt;
    logic [CNT_W-1:0] rem_cnt;
    logic [ID_W-1:0]  rem_id;
    logic             local_wins;

    always_comb begin
        c_d = c_q;
        if (!c_q.active) begin
            c_d.dyn       = cfg_dyn_i;
            c_d.stall_pol = cfg_stall_i;
        end
        if (tx_begin_i)                    c_d.active = 1'b1;
        else if (tx_abort_i || tx_commit_i) c_d.active = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign active_q = c_q.active;
    assign dyn_q    = c_q.dyn;
    assign dyn_eff  = c_q.active ? c_q.dyn : cfg_dyn_i;
    assign rem_cnt  = snoop_prio_i[CNT_W+ID_W-1:ID_W];
    assign rem_id   = snoop_prio_i[ID_W-1:0];
    assign loc_cnt  = dyn_eff ? work : stamp;
    assign prio_o   = {loc_cnt, core_id_i};

    txn_prio_track #(.CNT_W(CNT_W)) u_track (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .dyn_i        (dyn_eff),
        .active_i     (c_q.active),
        .tx_begin_i   (tx_begin_i),
        .tx_abort_i   (tx_abort_i),
        .retire_i     (retire_i),
        .snoop_valid_i(snoop_valid_i),
        .snoop_cnt_i  (rem_cnt),
        .stamp_o      (stamp),
        .work_o       (work)
    );

    txn_prio_cmp #(.CNT_W(CNT_W), .ID_W(ID_W)) u_cmp (
        .dyn_i       (c_q.dyn),
        .loc_cnt_i   (loc_cnt),
        .loc_id_i    (core_id_i),
        .rem_cnt_i   (rem_cnt),
        .rem_id_i    (rem_id),
        .local_wins_o(local_wins)
    );

    txn_prio_rectify u_rect (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .active_i    (c_q.active),
        .stall_pol_i (c_q.stall_pol),
        .tx_begin_i  (tx_begin_i),
        .tx_abort_i  (tx_abort_i),
        .tx_commit_i (tx_commit_i),
        .conflict_i  (conflict_i),
        .conf_req_i  (conf_req_i),
        .local_wins_i(local_wins),
        .resp_valid_i(resp_valid_i),
        .resp_other_i(resp_other_i),
        .notice_i    (notice_i),
        .abort_o     (abort_o),
        .stall_o     (stall_o),
        .lose_o      (lose_o)
    );
endmodule

// File: rtl/txn_prio_arbiter_chk.sv
module txn_prio_arbiter_chk #(
    parameter int CNT_W = 16,
    parameter int ID_W  = 3
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  tx_begin_i,
    input logic                  tx_commit_i,
    input logic                  tx_abort_i,
    input logic                  conflict_i,
    input logic                  notice_i,
    input logic [CNT_W+ID_W-1:0] prio_o,
    input logic                  abort_o,
    input logic                  stall_o,
    input logic                  lose_o,
    input logic                  active_q,
    input logic                  dyn_q
);
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |=> !abort_o); // R7
    AST_LOSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lose_o |=> !lose_o); // R9
    AST_LOSE_AFTER_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lose_o |-> $past(conflict_i)); // R9
    AST_NO_STALL_WITH_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(stall_o && abort_o)); // R8
    AST_STALL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o && !notice_i && !conflict_i && !tx_begin_i && !tx_abort_i && !tx_commit_i)
        |=> stall_o); // R8
    AST_ABORT_NEEDS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> $past(active_q)); // R11
    AST_STAMP_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_q && !dyn_q && !tx_begin_i && !tx_abort_i && !tx_commit_i)
        |=> $stable(prio_o[CNT_W+ID_W-1:ID_W])); // R12
endmodule

bind txn_prio_arbiter txn_prio_arbiter_chk #(.CNT_W(CNT_W), .ID_W(ID_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_begin_i (tx_begin_i),
    .tx_commit_i(tx_commit_i),
    .tx_abort_i (tx_abort_i),
    .conflict_i (conflict_i),
    .notice_i   (notice_i),
    .prio_o     (prio_o),
    .abort_o    (abort_o),
    .stall_o    (stall_o),
    .lose_o     (lose_o),
    .active_q   (active_q),
    .dyn_q      (dyn_q)
);

// File: tb/txn_prio_arbiter_bench.sv
`timescale 1ns/1ps
module txn_prio_arbiter_bench;
    localparam int CW = 4;
    localparam int IW = 2;
    localparam int PW = CW + IW;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic [IW-1:0] core_id = '0;
    logic          cfg_dyn = 1'b0, cfg_stall = 1'b0;
    logic          tx_begin = 1'b0, tx_commit = 1'b0, tx_abort = 1'b0, retire = 1'b0;
    logic          snoop_valid = 1'b0;
    logic [PW-1:0] snoop_prio = '0;
    logic          conflict = 1'b0, conf_req = 1'b0;
    logic          resp_valid = 1'b0, resp_other = 1'b0, notice = 1'b0;
    logic [PW-1:0] prio;
    logic          abort_w, stall_w, lose_w;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    txn_prio_arbiter #(.CNT_W(CW), .ID_W(IW)) u_txn_prio_arbiter (
        .clk_i(clk), .rst_ni(rst_ni), .core_id_i(core_id),
        .cfg_dyn_i(cfg_dyn), .cfg_stall_i(cfg_stall),
        .tx_begin_i(tx_begin), .tx_commit_i(tx_commit), .tx_abort_i(tx_abort),
        .retire_i(retire), .snoop_valid_i(snoop_valid), .snoop_prio_i(snoop_prio),
        .conflict_i(conflict), .conf_req_i(conf_req),
        .resp_valid_i(resp_valid), .resp_other_i(resp_other), .notice_i(notice),
        .prio_o(prio), .abort_o(abort_w), .stall_o(stall_w), .lose_o(lose_w)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 1'b0;
        @(negedge clk);
        rst_ni = 1'b1;
    endtask

    task automatic pulse_begin();
        tx_begin = 1'b1; @(negedge clk); tx_begin = 1'b0;
    endtask

    task automatic pulse_commit();
        tx_commit = 1'b1; @(negedge clk); tx_commit = 1'b0;
    endtask

    task automatic pulse_abort();
        tx_abort = 1'b1; @(negedge clk); tx_abort = 1'b0;
    endtask

    task automatic retire_n(input int n);
        if (n > 0) begin
            retire = 1'b1; repeat (n) @(negedge clk); retire = 1'b0;
        end
    endtask

    task automatic snoop_cnt(input int c);
        snoop_valid = 1'b1; snoop_prio = PW'(c * 4);
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    // one conflict cycle; outputs sampled on the following negedge
    task automatic raise_conflict(input bit req, input int rc, input int rid);
        conflict = 1'b1; conf_req = req; snoop_prio = PW'(rc * 4 + rid);
        @(negedge clk);
        conflict = 1'b0; conf_req = 1'b0;
    endtask

    function automatic int cnt_of(input logic [PW-1:0] p);
        return int'(p[PW-1:IW]);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        core_id = 2'd2;
        do_reset();
        chk("R1 abort", abort_w, 0);
        chk("R1 stall", stall_w, 0);
        chk("R1 lose", lose_w, 0);
        chk("R1 prio", prio, 2);

        // R2 begin increments counter, R3 snoop tracking, R12 fixed stamp
        pulse_begin();
        chk("R2 first stamp", prio, 1 * 4 + 2);
        pulse_commit();
        pulse_begin();
        chk("R2 second stamp", cnt_of(prio), 2);
        pulse_commit();
        snoop_cnt(9);
        pulse_begin();
        chk("R3 higher snoop adopted", cnt_of(prio), 10);
        pulse_commit();
        snoop_cnt(3);
        pulse_begin();
        chk("R3 lower snoop ignored", cnt_of(prio), 11);
        pulse_commit();
        cfg_dyn = 1'b1;
        snoop_cnt(14);
        cfg_dyn = 1'b0;
        pulse_begin();
        chk("R3 snoop ignored in work scheme", cnt_of(prio), 12);
        snoop_cnt(14);
        chk("R12 stamp fixed in flight", cnt_of(prio), 12);
        pulse_commit();
        pulse_begin();
        chk("R12 counter absorbed snoop", cnt_of(prio), 15);
        pulse_commit();
        pulse_begin();
        chk("R2 saturation", cnt_of(prio), 15);
        pulse_commit();
        snoop_valid = 1'b1; snoop_prio = PW'(6 * 4); tx_begin = 1'b1;
        @(negedge clk);
        snoop_valid = 1'b0; tx_begin = 1'b0;
        chk("R3 snoop and begin same cycle", cnt_of(prio), 15);

        // R5 work count, R10 config frozen while active
        do_reset();
        cfg_dyn = 1'b1;
        pulse_begin();
        chk("R5 cleared at begin", cnt_of(prio), 0);
        retire_n(3);
        chk("R5 counts retires", cnt_of(prio), 3);
        cfg_dyn = 1'b0;
        @(negedge clk);
        chk("R10 scheme frozen in flight", cnt_of(prio), 3);
        cfg_dyn = 1'b1;
        pulse_commit();
        retire_n(2);
        chk("R5 retire ignored when idle", cnt_of(prio), 3);
        pulse_begin();
        retire_n(20);
        chk("R5 saturation", cnt_of(prio), 15);
        pulse_abort();
        chk("R5 cleared at abort", cnt_of(prio), 0);

        // R11 conflicts with no transaction active
        do_reset();
        cfg_dyn = 1'b0; cfg_stall = 1'b1; core_id = 2'd3;
        raise_conflict(1'b0, 15, 0);
        chk("R11 no lose when idle", lose_w, 0);
        raise_conflict(1'b1, 0, 0);
        chk("R11 no stall when idle", stall_w, 0);
        chk("R11 no abort when idle", abort_w, 0);

        // R8 stall policy and release
        pulse_begin();
        raise_conflict(1'b1, 0, 0);
        chk("R8 stall raised", stall_w, 1);
        chk("R8 no abort when stalling", abort_w, 0);
        repeat (3) @(negedge clk);
        chk("R8 stall held", stall_w, 1);
        notice = 1'b1; @(negedge clk); notice = 1'b0;
        chk("R8 stall released", stall_w, 0);
        // R10 policy frozen: stall latched, change ignored
        cfg_stall = 1'b0;
        raise_conflict(1'b1, 0, 0);
        chk("R10 policy frozen in flight", stall_w, 1);
        pulse_abort();
        // R8 abort policy
        pulse_begin();
        raise_conflict(1'b1, 0, 0);
        chk("R8 abort pulse", abort_w, 1);
        chk("R8 no stall under abort policy", stall_w, 0);
        @(negedge clk);
        chk("R8 abort one cycle", abort_w, 0);
        pulse_abort();

        // R7 pending abort and cancellation
        pulse_begin();
        raise_conflict(1'b0, 0, 0);
        chk("R7 no abort before response", abort_w, 0);
        repeat (2) @(negedge clk);
        chk("R7 still waiting", abort_w, 0);
        resp_valid = 1'b1; resp_other = 1'b1; @(negedge clk);
        resp_valid = 1'b0; resp_other = 1'b0;
        chk("R7 cancelled by other core", abort_w, 0);
        raise_conflict(1'b0, 15, 0);
        chk("R9 win after cancel", lose_w, 1);
        @(negedge clk);
        chk("R9 lose one cycle", lose_w, 0);
        raise_conflict(1'b0, 0, 0);
        resp_valid = 1'b1; @(negedge clk); resp_valid = 1'b0;
        chk("R7 abort after response", abort_w, 1);
        pulse_abort();

        // R4 timestamp comparison sweep, R9 lose, R7 abort on loss
        for (int lid = 0; lid < 4; lid++)
            for (int lc = 1; lc < 16; lc++)
                for (int rc = 0; rc < 16; rc++)
                    for (int rid = 0; rid < 4; rid++) begin
                        bit win;
                        win = (lc * 4 + lid) < (rc * 4 + rid);
                        core_id = IW'(lid); cfg_dyn = 1'b0; cfg_stall = 1'b0;
                        do_reset();
                        snoop_valid = 1'b1; snoop_prio = PW'((lc - 1) * 4); tx_begin = 1'b1;
                        @(negedge clk);
                        snoop_valid = 1'b0; tx_begin = 1'b0;
                        raise_conflict(1'b0, rc, rid);
                        chk("R4 timestamp win", lose_w, int'(win));
                        if (!win) begin
                            resp_valid = 1'b1; @(negedge clk); resp_valid = 1'b0;
                            chk("R7 abort after loss", abort_w, 1);
                        end
                    end

        // R6 work comparison sweep
        for (int lid = 0; lid < 4; lid++)
            for (int lc = 0; lc < 16; lc++)
                for (int rc = 0; rc < 16; rc++)
                    for (int rid = 0; rid < 4; rid++) begin
                        bit win;
                        win = (lc > rc) || (lc == rc && lid < rid);
                        core_id = IW'(lid); cfg_dyn = 1'b1; cfg_stall = 1'b0;
                        do_reset();
                        pulse_begin();
                        retire_n(lc);
                        raise_conflict(1'b0, rc, rid);
                        chk("R6 work win", lose_w, int'(win));
                    end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule